// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two square-wave channels of an incremental rotary or linear encoder into a signed position count. Each raw channel first passes through its own synchronizer. A decoder then compares the present two-bit channel state with the state one cycle earlier. Every legal Gray-code step yields one single-cycle count pulse, so each of the four edges in an encoder period counts once. That gives four times the resolution of a single channel.

The direction of motion comes from which channel leads. A forward step adds one to a free-running signed counter and a reverse step subtracts one. A slow sample strobe, for example 1 kHz derived from the 50 MHz system clock, copies the counter into a holding register that a processor reads at its leisure. A step in which both channels change together cannot be resolved. Such a step leaves the count alone and raises a sticky fault flag.

Top module: `qenc_position_counter`

## Requirements
- R1: Each raw channel passes through SYNC_STAGES (default 2) flip-flops. A channel change driven before clock edge E1 updates the internal count at edge E3, so a strobe sampled at E3 still captures the old count and a strobe sampled at E4 captures the new one.
- R2: The channel state is written as {A,B}. A forward step is any of 00→10, 10→11, 11→01 and 01→00, which is A leading B. Each forward step adds one to the count and sets `dir_fwd` to 1.
- R3: A reverse step is any of 00→01, 01→11, 11→10 and 10→00, which is B leading A. Each reverse step subtracts one from the count and sets `dir_fwd` to 0.
- R4: All four edges of one encoder period count, so one full forward period changes the count by exactly +4.
- R5: While neither channel changes, the count stays as it is, and repeated strobes return the same value.
- R6: A step in which both channels change at once (00↔11 or 10↔01) leaves both the count and `dir_fwd` unchanged and sets `step_fault`.
- R7: `step_fault` stays at 1 through any later motion and returns to 0 only on reset.
- R8: The count is CNT_W bits (default 32), two's complement, and wraps. The largest value plus one gives the most negative value, and the most negative value minus one gives the largest.
- R9: `held_count` takes the count, as it stood before that edge, on every clock edge at which `sample_stb` is 1. On every other edge it keeps its value.
- R10: While `rst_n` is 0, `held_count` and the count are 0, `dir_fwd` is 1 and `step_fault` is 0. During the first SYNC_STAGES+1 cycles after reset, the decoder only loads the channel state, so the initial channel level produces no count and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw encoder channel A |
| enc_b | input | 1 | Raw encoder channel B |
| sample_stb | input | 1 | Capture strobe for the holding register |
| dir_fwd | output | 1 | 1 after a forward step, 0 after a reverse step |
| step_fault | output | 1 | Sticky flag for an unresolvable double change |
| held_count | output | CNT_W | Signed count captured by the last strobe |

## Verification
A channel change reaches the internal count and `dir_fwd` at the third rising edge after it is driven. The strobe copy appears one edge after the strobe is sampled. The bench therefore waits five cycles after each normal step before it strobes, and it compares at the falling edge that follows the capture edge. A dedicated latency case strobes at the third and at the fourth edge and expects the old value and then the new value. A second instance with a 4-bit count runs beside the default one, so that wrap in both directions is reached in a few steps.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_FWD  = 2'd1,
    MV_REV  = 2'd2,
    MV_BAD  = 2'd3
  } move_t;

  // State that follows s when channel A leads channel B; s = {A,B}
  function automatic logic [1:0] lead_a_next(input logic [1:0] s);
    case (s)
      2'b00:   lead_a_next = 2'b10;
      2'b10:   lead_a_next = 2'b11;
      2'b11:   lead_a_next = 2'b01;
      default: lead_a_next = 2'b00;
    endcase
  endfunction

  // Classify one sampled step of the two-channel state
  function automatic move_t classify(input logic [1:0] prev, input logic [1:0] cur);
    if (prev == cur)                    classify = MV_NONE;
    else if ((prev ^ cur) == 2'b11)     classify = MV_BAD;
    else if (cur == lead_a_next(prev))  classify = MV_FWD;
    else                                classify = MV_REV;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
  import qenc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab,
  output move_t      mv
);
  localparam int LIVE_AT = STAGES + 1;
  localparam int WW      = $clog2(LIVE_AT + 1);

  logic [1:0]    prev_q;
  logic [WW-1:0] warm_q;
  logic          live;

  assign live = (warm_q == WW'(LIVE_AT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      warm_q <= '0;
    end else begin
      prev_q <= ab;
      if (!live) warm_q <= warm_q + WW'(1);
    end
  end

  assign mv = live ? classify(prev_q, ab) : MV_NONE;
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  move_t                   mv,
  input  logic                    sample_stb,
  output logic signed [CNT_W-1:0] cnt_q,
  output logic signed [CNT_W-1:0] held_q,
  output logic                    dir_q,
  output logic                    err_q
);
  logic signed [CNT_W-1:0] cnt_d;

  always_comb begin
    case (mv)
      MV_FWD:  cnt_d = cnt_q + CNT_W'(1);
      MV_REV:  cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= '0;
      dir_q  <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (sample_stb) held_q <= cnt_q;
      if (mv == MV_FWD) dir_q <= 1'b1;
      else if (mv == MV_REV) dir_q <= 1'b0;
      if (mv == MV_BAD) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/qenc_position_counter.sv
module qenc_position_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enc_a,
  input  logic                    enc_b,
  input  logic                    sample_stb,
  output logic                    dir_fwd,
  output logic                    step_fault,
  output logic signed [CNT_W-1:0] held_count
);
  logic [1:0]              ab_sync;
  move_t                   mv;
  logic                    step_up;
  logic                    step_dn;
  logic                    bad_step;
  logic signed [CNT_W-1:0] cnt;

  qenc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({enc_a, enc_b}), .q(ab_sync)
  );

  qenc_decoder #(.STAGES(SYNC_STAGES)) u_dec (
    .clk(clk), .rst_n(rst_n), .ab(ab_sync), .mv(mv)
  );

  qenc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mv(mv), .sample_stb(sample_stb),
    .cnt_q(cnt), .held_q(held_count), .dir_q(dir_fwd), .err_q(step_fault)
  );

  // Named internal events for the checker
  assign step_up  = (mv == MV_FWD);
  assign step_dn  = (mv == MV_REV);
  assign bad_step = (mv == MV_BAD);
endmodule

// File: rtl/qenc_checks.sv
module qenc_checks #(
  parameter int CNT_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_stb,
  input logic                    step_up,
  input logic                    step_dn,
  input logic                    bad_step,
  input logic signed [CNT_W-1:0] cnt,
  input logic signed [CNT_W-1:0] held,
  input logic                    dir_fwd,
  input logic                    err
);
  a_r2_up_adds: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> (cnt == $past(cnt) + CNT_W'(1)) && dir_fwd);

  a_r3_down_subtracts: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> (cnt == $past(cnt) - CNT_W'(1)) && !dir_fwd);

  a_r6_bad_holds: assert property (@(posedge clk) disable iff (!rst_n)
    bad_step |=> (cnt == $past(cnt)) && err && (dir_fwd == $past(dir_fwd)));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up || step_dn) |=> cnt == $past(cnt));

  a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn, bad_step}));

  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> held == $past(cnt));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(held));
endmodule

bind qenc_position_counter qenc_checks #(.CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
  .step_up(step_up), .step_dn(step_dn), .bad_step(bad_step),
  .cnt(cnt), .held(held_count), .dir_fwd(dir_fwd), .err(step_fault)
);

// File: tb/tb_qenc_position_counter.sv
module tb_qenc_position_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, sample_stb = 1'b0;
  logic dir_fwd, step_fault, dir_s, fault_s;
  logic signed [31:0] held_count;
  logic signed [3:0]  held_small;

  always #10 clk = ~clk;

  qenc_position_counter dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .sample_stb(sample_stb), .dir_fwd(dir_fwd), .step_fault(step_fault),
    .held_count(held_count)
  );

  qenc_position_counter #(.CNT_W(4)) dut_small (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .sample_stb(sample_stb), .dir_fwd(dir_s), .step_fault(fault_s),
    .held_count(held_small)
  );

  typedef struct {
    string req;
    int    cnt;
    logic  dir;
    logic  err;
  } item_t;

  item_t q[$];
  int checks = 0, failures = 0;
  int pos = 0, ph = 0;
  logic m_dir = 1'b1, m_err = 1'b0;
  logic [1:0] gray [4] = '{2'b00, 2'b10, 2'b11, 2'b01};

  task automatic check(string req, bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive a new {A,B} level at a falling edge, then wait settle cycles
  task automatic drive_ab(logic [1:0] v, int settle);
    @(negedge clk);
    {enc_a, enc_b} = v;
    repeat (settle) @(negedge clk);
  endtask

  task automatic move(bit fwd, int settle);
    ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
    drive_ab(gray[ph], settle);
  endtask

  // strobe for one edge and queue what the capture must show
  task automatic sample(string req, int exp_cnt);
    item_t it;
    it.req = req; it.cnt = exp_cnt; it.dir = m_dir; it.err = m_err;
    q.push_back(it);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  task automatic step_chk(string req, bit fwd);
    move(fwd, 5);
    pos = fwd ? pos + 1 : pos - 1;
    m_dir = fwd;
    sample(req, pos);
  endtask

  // monitor: compare at the falling edge after each capture edge
  initial begin
    forever begin
      @(posedge clk);
      if (sample_stb && rst_n) begin
        item_t it;
        @(negedge clk);
        it = q.pop_front();
        check(it.req, held_count == it.cnt, "held_count", held_count, it.cnt);
        check(it.req, held_small == 4'(it.cnt), "held_small", held_small, 4'(it.cnt));
        check(it.req, dir_fwd == it.dir && dir_s == it.dir, "dir_fwd", dir_fwd, it.dir);
        check(it.req, step_fault == it.err && fault_s == it.err, "step_fault", step_fault, it.err);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state while and just after reset
    check("R10", held_count == 0, "held_count", held_count, 0);
    check("R10", dir_fwd == 1'b1, "dir_fwd", dir_fwd, 1);
    check("R10", step_fault == 1'b0, "step_fault", step_fault, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    sample("R10", 0);

    // R1: latency, strobe at third edge sees old, at fourth sees new
    move(1'b1, 2);
    sample("R1", 0);
    pos = 1;
    sample("R1", 1);

    // R2 and R4: complete the forward period, +4 in total
    for (int i = 0; i < 3; i++) step_chk("R2", 1'b1);
    sample("R4", 4);

    // R5: no motion, repeated strobes
    repeat (7) @(negedge clk);
    sample("R5", 4);
    sample("R5", 4);

    // R3: reverse steps
    for (int i = 0; i < 6; i++) step_chk("R3", 1'b0);

    // R6: both channels flip together
    ph = (ph + 2) % 4;
    drive_ab(gray[ph], 5);
    m_err = 1'b1;
    sample("R6", pos);

    // R7: fault persists through valid motion
    for (int i = 0; i < 3; i++) step_chk("R7", 1'b1);

    // R8: forward past 7 in the 4-bit instance, then back below -8
    for (int i = 0; i < 10; i++) step_chk("R8", 1'b1);
    for (int i = 0; i < 20; i++) step_chk("R8", 1'b0);

    // R9: strobe idle, motion must not reach held_count
    move(1'b1, 6);
    pos = pos + 1; m_dir = 1'b1;
    check("R9", held_count == pos - 1, "held_count", held_count, pos - 1);
    sample("R9", pos);

    // R7 and R10: reset clears the fault
    rst_n = 1'b0;
    @(negedge clk);
    check("R7", step_fault == 1'b0, "step_fault", step_fault, 0);
    check("R10", held_count == 0, "held_count", held_count, 0);
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule